// File: doc/BRIEF.md
# BCD Add-Sixes Correction Generator

This block produces the decimal correction word needed when two packed BCD numbers are added with a plain binary adder. It adds the two operands as unsigned binary numbers, keeping the carry out of the most significant bit. From the sum and the operand bits it recovers, for every 4-bit digit position, whether that digit passed a carry to the next digit up. A digit that passed no carry gets the value 6 in the output word. A digit that did pass a carry gets 0.

A pipeline places this word beside the binary sum to finish a decimal addition. The correction step itself, and any check that the inputs are valid BCD, stay outside. A start strobe loads a pair of operands. One clock later the registered correction word appears together with a one-cycle done strobe. The word then holds until the next start.

Top module: `bcd6_gen_top`

## Requirements
- R1: While rst_ni is low, and right after it is released, corr_o is all zeros and done_o is 0.
- R2: done_o is 1 in exactly the cycle after a cycle in which start_i was sampled high, and 0 in every other cycle.
- R3: After a start, digit n of corr_o (bits 4n+3 down to 4n) is 0x6 when the unsigned binary sum ra_i + rb_i carries no 1 out of bit 4n+3, and 0x0 when it does.
- R4: Every 4-bit digit of corr_o is always either 0x6 or 0x0.
- R5: All-zero operands give corr_o = 0x6666666666666666.
- R6: The top digit is evaluated like the others, using the carry out of bit 63. When bit 63 is set in both operands, corr_o bits 63 to 60 are 0x0.
- R7: Non-decimal digit values 0xA to 0xF follow the same rule with no special handling. For example, all-ones operands give corr_o = 0.
- R8: While start_i is low, corr_o keeps its previous value whatever ra_i and rb_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the operands this cycle |
| ra_i | input | 64 | First operand |
| rb_i | input | 64 | Second operand |
| corr_o | output | 64 | Correction word, 0x6 or 0x0 per digit |
| done_o | output | 1 | Result valid, one cycle after start |

## Verification
The bench builds the block with its default parameters: sixteen 4-bit digits and a correction value of 6. These defaults give the full 64-bit word, including the carry out of bit 63 into the top digit. They also make it possible to drive carries that ripple through all sixteen digits. Random 64-bit pairs, and pairs made only of valid decimal digits, are compared against a digit-by-digit ripple model.

// File: rtl/bcd6_pkg.sv
package bcd6_pkg;
  localparam int unsigned DEF_DIGITS  = 16;
  localparam int unsigned DEF_DIGIT_W = 4;
  localparam int unsigned DEF_CORR    = 6;
endpackage

// File: rtl/bcd6_sum.sv
// Unsigned binary adder, carry out kept as top bit.
module bcd6_sum #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o
);
  always_comb begin
    sum_o = {1'b0, a_i} + {1'b0, b_i};
  end
endmodule

// File: rtl/bcd6_carry.sv
// Recovers the carry out of each digit from sum and operand bits.
module bcd6_carry #(
  parameter int unsigned DIGITS  = 16,
  parameter int unsigned DIGIT_W = 4,
  localparam int unsigned W      = DIGITS * DIGIT_W
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [W:0]        sum_i,
  output logic [DIGITS-1:0] carry_o
);
  logic [W:0] a_ext, b_ext, cin_vec;
  logic       unused_cin;

  assign a_ext   = {1'b0, a_i};
  assign b_ext   = {1'b0, b_i};
  // carry into every bit position
  assign cin_vec = sum_i ^ a_ext ^ b_ext;
  assign unused_cin = ^cin_vec;

  for (genvar n = 0; n < DIGITS; n++) begin : g_tap
    assign carry_o[n] = cin_vec[(n+1)*DIGIT_W];
  end
endmodule

// File: rtl/bcd6_form.sv
// Places CORR in each digit without carry out, zero elsewhere.
module bcd6_form #(
  parameter int unsigned DIGITS         = 16,
  parameter int unsigned DIGIT_W        = 4,
  parameter logic [DIGIT_W-1:0] CORR    = 4'h6,
  localparam int unsigned W             = DIGITS * DIGIT_W
) (
  input  logic [DIGITS-1:0] carry_i,
  output logic [W-1:0]      corr_o
);
  for (genvar n = 0; n < DIGITS; n++) begin : g_dig
    assign corr_o[n*DIGIT_W +: DIGIT_W] = carry_i[n] ? '0 : CORR;
  end
endmodule

// File: rtl/bcd6_gen_top.sv
module bcd6_gen_top #(
  parameter int unsigned DIGITS         = bcd6_pkg::DEF_DIGITS,
  parameter int unsigned DIGIT_W        = bcd6_pkg::DEF_DIGIT_W,
  parameter logic [DIGIT_W-1:0] CORR    = DIGIT_W'(bcd6_pkg::DEF_CORR),
  localparam int unsigned W             = DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] ra_i,
  input  logic [W-1:0] rb_i,
  output logic [W-1:0] corr_o,
  output logic         done_o
);
  logic [W:0]        sum;
  logic [DIGITS-1:0] carry;
  logic [W-1:0]      corr_d, corr_q;
  logic              done_q;

  bcd6_sum #(.W(W)) u_sum (
    .a_i  (ra_i),
    .b_i  (rb_i),
    .sum_o(sum)
  );

  bcd6_carry #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_carry (
    .a_i    (ra_i),
    .b_i    (rb_i),
    .sum_i  (sum),
    .carry_o(carry)
  );

  bcd6_form #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .CORR(CORR)) u_form (
    .carry_i(carry),
    .corr_o (corr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) corr_q <= corr_d;
    end
  end

  assign corr_o = corr_q;
  assign done_o = done_q;
endmodule

// File: rtl/bcd6_gen_chk.sv
module bcd6_gen_chk #(
  parameter int unsigned DIGITS         = 16,
  parameter int unsigned DIGIT_W        = 4,
  parameter logic [DIGIT_W-1:0] CORR    = 4'h6,
  localparam int unsigned W             = DIGITS * DIGIT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] ra_i,
  input logic [W-1:0] rb_i,
  input logic [W-1:0] corr_o,
  input logic         done_o
);
  // R2
  done_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(corr_o));

  // R5
  zero_operands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ra_i == '0 && rb_i == '0) |=> corr_o == {DIGITS{CORR}});

  // R6
  top_digit_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ra_i[W-1] && rb_i[W-1]) |=> corr_o[W-1 -: DIGIT_W] == '0);

  // R7
  all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ra_i == '1 && rb_i == '1) |=> corr_o == '0);

  for (genvar n = 0; n < DIGITS; n++) begin : g_dig
    // R4
    digit_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corr_o[n*DIGIT_W +: DIGIT_W] == '0 || corr_o[n*DIGIT_W +: DIGIT_W] == CORR);
  end
endmodule

bind bcd6_gen_top bcd6_gen_chk #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .CORR(CORR)) chk_i (.*);

// File: tb/bcd6_gen_top_tb_top.sv
`timescale 1ns/1ps
module bcd6_gen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ra = '0, rb = '0;
  logic [63:0] corr;
  logic        done;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  bcd6_gen_top dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .ra_i   (ra),
    .rb_i   (rb),
    .corr_o (corr),
    .done_o (done)
  );

  // {ra, rb, expected}
  localparam logic [191:0] VEC [0:8] = '{
    {64'h0000000000000000, 64'h0000000000000000, 64'h6666666666666666},
    {64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000},
    {64'h9999999999999999, 64'h7777777777777777, 64'h0000000000000000},
    {64'h8000000000000000, 64'h8000000000000000, 64'h0666666666666666},
    {64'h000000000000000F, 64'h0000000000000001, 64'h6666666666666660},
    {64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'h6666666666666666},
    {64'h5555555555555555, 64'hAAAAAAAAAAAAAAAB, 64'h0000000000000000},
    {64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h6666666666666666},
    {64'h0000000000000F00, 64'h0000000000000100, 64'h6666666666666066}
  };

  function automatic logic [63:0] ref_corr(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    logic        c = 1'b0;
    for (int n = 0; n < 16; n++) begin
      logic [4:0] t;
      t = {1'b0, a[n*4 +: 4]} + {1'b0, b[n*4 +: 4]} + {4'b0, c};
      c = t[4];
      r[n*4 +: 4] = c ? 4'h0 : 4'h6;
    end
    return r;
  endfunction

  function automatic logic digits_ok(input logic [63:0] v);
    for (int n = 0; n < 16; n++)
      if (v[n*4 +: 4] != 4'h0 && v[n*4 +: 4] != 4'h6) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, output logic [63:0] res);
    @(negedge clk);
    start = 1'b1; ra = a; rb = b;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done after start", {63'b0, done}, 64'd1);
    res = corr;
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] res, held;
    // R1 during reset
    repeat (3) @(negedge clk);
    chk("R1 corr in reset", corr, '0);
    chk("R1 done in reset", {63'b0, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 corr after release", corr, '0);
    chk("R2 no done without start", {63'b0, done}, '0);

    // R3 table walk
    for (int i = 0; i < 9; i++) begin
      run(VEC[i][191:128], VEC[i][127:64], res);
      chk("R3 table vector", res, VEC[i][63:0]);
      chk("R4 digit values", {63'b0, digits_ok(res)}, 64'd1);
    end

    // R5 all zero
    run('0, '0, res);
    chk("R5 zero operands", res, 64'h6666666666666666);

    // R6 top digit carry only
    run(64'hF000000000000000, 64'h1000000000000000, res);
    chk("R6 top digit carry", res, 64'h0666666666666666);
    run(64'h7000000000000000, 64'h8000000000000000, res);
    chk("R6 top digit no carry", res, 64'h6666666666666666);

    // R7 invalid digits
    run('1, '1, res);
    chk("R7 all ones", res, '0);
    run(64'hABCDEFABCDEFABCD, 64'h0000000000000000, res);
    chk("R7 invalid no carry", res, 64'h6666666666666666);

    // R8 hold while idle
    run(64'h0000000000000F00, 64'h0000000000000100, held);
    @(negedge clk);
    ra = '1; rb = 64'h1;
    chk("R2 done drops", {63'b0, done}, '0);
    repeat (3) @(negedge clk);
    chk("R8 hold idle", corr, held);
    chk("R2 done stays low", {63'b0, done}, '0);

    // R2 back to back starts
    @(negedge clk);
    start = 1'b1; ra = '0; rb = '0;
    @(negedge clk);
    ra = 64'h8000000000000000; rb = 64'h8000000000000000;
    chk("R2 b2b first done", {63'b0, done}, 64'd1);
    chk("R3 b2b first", corr, 64'h6666666666666666);
    @(negedge clk);
    start = 1'b0;
    chk("R2 b2b second done", {63'b0, done}, 64'd1);
    chk("R3 b2b second", corr, 64'h0666666666666666);
    @(negedge clk);
    chk("R2 b2b done low", {63'b0, done}, '0);

    // R3 random full patterns
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run(a, b, res);
      chk("R3 random", res, ref_corr(a, b));
      chk("R4 random digits", {63'b0, digits_ok(res)}, 64'd1);
    end

    // R3 random valid decimal digits
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      for (int n = 0; n < 16; n++) begin
        a[n*4 +: 4] = 4'($urandom_range(9));
        b[n*4 +: 4] = 4'($urandom_range(9));
      end
      run(a, b, res);
      chk("R3 random decimal", res, ref_corr(a, b));
    end

    // R1 asynchronous reset mid run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear corr", corr, '0);
    chk("R1 async clear done", {63'b0, done}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule